// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell

This block sits beside a dual-port memory with 10-bit addresses and gives the two processors on its ports a doorbell. Each port has one interrupt output. The block watches each port's select, write, output-enable, address and busy inputs on every clock. When one port writes to the mailbox word that belongs to the other port, that other port's interrupt rises. When the receiving port then reads its own mailbox word, its interrupt is cleared.

The two mailbox words are the top two locations of the address space. 0x3FE belongs to the left port and 0x3FF belongs to the right port. Their contents are ordinary memory data that the array stores, so this block never touches them. A software stack that ignores the interrupts can use both words as plain storage.

A busy condition on the acting port cancels whatever that port's access would have done to a flag. A global enable forces both interrupts inactive. The interrupt outputs are registered and active-low.

Top module: `mbx_irq`

## Requirements
- R1: After reset, and after any reset applied during operation, both `irq_l_n` and `irq_r_n` read 1 (inactive).
- R2: A port write means `x_sel`=1 and `x_we`=1 in the same cycle. A right-port write to address 0x3FE (2^ADDR_W−2) drives `irq_l_n` to 0 from the clock edge at which it is sampled. A write with `x_sel`=0 does nothing.
- R3: A left-port write to address 0x3FF (2^ADDR_W−1) drives `irq_r_n` to 0 from the clock edge at which it is sampled.
- R4: A left-port access with `l_sel`=1 and `l_oe`=1 at 0x3FE returns `irq_l_n` to 1 at the next edge, whatever the value of `l_we`.
- R5: A right-port access with `r_sel`=1 and `r_oe`=1 at 0x3FF returns `irq_r_n` to 1 at the next edge, whatever the value of `r_we`.
- R6: When the busy input of the acting port is 1 (`r_busy` for a right write or a right clear, `l_busy` for a left write or a left clear), that access leaves the flag unchanged.
- R7: When a set and a clear of the same flag are sampled in the same cycle, the set wins and the interrupt goes to or stays at 0.
- R8: While `en`=0, both outputs are 1 from the next edge on. Sets sampled while `en`=0 are discarded and do not show up after `en` returns to 1.
- R9: Accesses to any other address, a mailbox access without output enable, and a port writing to its own mailbox word (with `x_oe`=0) leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Doorbell enable; when 0, both flags are cleared and held |
| l_sel | input | 1 | Left port chip select, active high |
| l_we | input | 1 | Left port write strobe, active high |
| l_oe | input | 1 | Left port output enable, active high |
| l_busy | input | 1 | Left port busy; suppresses left set and clear |
| l_addr | input | ADDR_W | Left port address |
| r_sel | input | 1 | Right port chip select, active high |
| r_we | input | 1 | Right port write strobe, active high |
| r_oe | input | 1 | Right port output enable, active high |
| r_busy | input | 1 | Right port busy; suppresses right set and clear |
| r_addr | input | ADDR_W | Right port address |
| irq_l_n | output | 1 | Left interrupt, registered, active low |
| irq_r_n | output | 1 | Right interrupt, registered, active low |

## Verification
The assertions check the per-cycle flag rules on every cycle: a decoded set forces the interrupt low at the next edge, a clear with no set raises it, busy freezes it, no event holds it, and disable forces both outputs high. Those properties are stated in terms of the internal set and clear wires. Only the bench scenarios show that the pin-level decode produces those wires correctly. That covers the exact mailbox addresses, the fact that the write level does not matter for a clear, a port writing its own mailbox word, and a dropped set while disabled staying lost after re-enable. The bench also covers a reset applied while a flag is pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Mailbox word of a side: top two words of the address space.
  function automatic logic [31:0] box_addr(input int aw, input side_e s);
    return (32'd1 << aw) - 32'd2 + 32'(s);
  endfunction

  // Next flag value: disable clears, set beats clear, otherwise hold.
  function automatic logic flag_next(input logic en, input logic set,
                                     input logic clr, input logic q);
    if (!en)      return 1'b0;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    else          return q;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              sel,
  input  logic              we,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              post,
  output logic              ack
);
  logic hit_own, hit_peer, live;

  assign live     = sel & ~busy;
  assign hit_own  = (addr == OWN_BOX);
  assign hit_peer = (addr == PEER_BOX);

  // Write into the peer's mailbox rings the peer.
  assign post = live & we & hit_peer;
  // Read-side access of the own mailbox acknowledges; write level ignored.
  assign ack  = live & oe & hit_own;
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= mbx_pkg::flag_next(en, set, clr, flag);
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              irq_l_n,
  output logic              irq_r_n
);
  import mbx_pkg::*;

  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'(box_addr(ADDR_W, SIDE_L));
  localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'(box_addr(ADDR_W, SIDE_R));

  logic [NPORT-1:0]             sel_v, we_v, oe_v, busy_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0]             post_w, ack_w, set_w, clr_w, flag_q;

  assign sel_v  = {r_sel, l_sel};
  assign we_v   = {r_we, l_we};
  assign oe_v   = {r_oe, l_oe};
  assign busy_v = {r_busy, l_busy};
  assign addr_v = {r_addr, l_addr};

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (gi == 0) ? BOX_L : BOX_R;
    localparam logic [ADDR_W-1:0] PEER = (gi == 0) ? BOX_R : BOX_L;

    mbx_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .sel (sel_v[gi]),
      .we  (we_v[gi]),
      .oe  (oe_v[gi]),
      .busy(busy_v[gi]),
      .addr(addr_v[gi]),
      .post(post_w[gi]),
      .ack (ack_w[gi])
    );

    assign set_w[gi] = post_w[NPORT-1-gi];
    assign clr_w[gi] = ack_w[gi];

    mbx_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .set  (set_w[gi]),
      .clr  (clr_w[gi]),
      .flag (flag_q[gi])
    );
  end

  assign irq_l_n = ~flag_q[0];
  assign irq_r_n = ~flag_q[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       l_busy,
  input logic       r_busy,
  input logic [1:0] set_w,
  input logic [1:0] clr_w,
  input logic       irq_l_n,
  input logic       irq_r_n
);
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (irq_l_n && irq_r_n));
  p_set_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_w[0]) |=> !irq_l_n);
  p_set_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_w[1]) |=> !irq_r_n);
  p_clr_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_w[0] && !set_w[0]) |=> irq_l_n);
  p_clr_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_w[1] && !set_w[1]) |=> irq_r_n);
  p_busy_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && l_busy && !set_w[0]) |=> $stable(irq_l_n));
  p_busy_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && r_busy && !set_w[1]) |=> $stable(irq_r_n));
  p_hold_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_w[0] && !clr_w[0]) |=> $stable(irq_l_n));
  p_hold_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_w[1] && !clr_w[1]) |=> $stable(irq_r_n));
endmodule

bind mbx_irq mbx_irq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .l_busy (l_busy),
  .r_busy (r_busy),
  .set_w  (set_w),
  .clr_w  (clr_w),
  .irq_l_n(irq_l_n),
  .irq_r_n(irq_r_n)
);

// File: tb/mbx_irq_tb.sv
`timescale 1ns/1ps
module mbx_irq_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic l_sel = 0, l_we = 0, l_oe = 0, l_busy = 0;
  logic r_sel = 0, r_we = 0, r_oe = 0, r_busy = 0;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic irq_l_n, irq_r_n;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  mbx_irq #(.ADDR_W(10)) u_dut (.*);

  // ctl bits: {sel, we, oe, busy}; exp: {irq_l_n, irq_r_n}
  typedef struct packed {
    logic [3:0] lc; logic [9:0] la;
    logic [3:0] rc; logic [9:0] ra;
    logic [1:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 10'h000, 4'b0000, 10'h000, 2'b11, 4'd1},  // R1 idle
    '{4'b0000, 10'h000, 4'b1100, 10'h3FE, 2'b01, 4'd2},  // R2 right rings left
    '{4'b0000, 10'h000, 4'b0000, 10'h000, 2'b01, 4'd9},  // R9 hold
    '{4'b1010, 10'h3FD, 4'b0000, 10'h000, 2'b01, 4'd9},  // R9 wrong address
    '{4'b1000, 10'h3FE, 4'b0000, 10'h000, 2'b01, 4'd9},  // R9 no output enable
    '{4'b1010, 10'h3FE, 4'b0000, 10'h000, 2'b11, 4'd4},  // R4 clear by read
    '{4'b1100, 10'h3FF, 4'b0000, 10'h000, 2'b10, 4'd3},  // R3 left rings right
    '{4'b0000, 10'h000, 4'b1011, 10'h3FF, 2'b10, 4'd6},  // R6 busy blocks clear
    '{4'b0000, 10'h000, 4'b1110, 10'h3FF, 2'b11, 4'd5},  // R5 clear, we=1
    '{4'b0000, 10'h000, 4'b1101, 10'h3FE, 2'b11, 4'd6},  // R6 busy blocks set
    '{4'b1010, 10'h3FE, 4'b1100, 10'h3FE, 2'b01, 4'd7},  // R7 set beats clear
    '{4'b1110, 10'h3FE, 4'b0000, 10'h000, 2'b11, 4'd4},  // R4 clear with we=1
    '{4'b0100, 10'h3FF, 4'b0000, 10'h000, 2'b11, 4'd2},  // R2 no sel, no write
    '{4'b1100, 10'h3FF, 4'b1010, 10'h3FF, 2'b10, 4'd7},  // R7 right side
    '{4'b1100, 10'h3FE, 4'b0000, 10'h000, 2'b10, 4'd9}   // R9 own-box write
  };

  task automatic drive(input vec_t v);
    {l_sel, l_we, l_oe, l_busy} = v.lc; l_addr = v.la;
    {r_sel, r_we, r_oe, r_busy} = v.rc; r_addr = v.ra;
  endtask

  task automatic check(input int req, input logic [1:0] exp);
    total++;
    if ({irq_l_n, irq_r_n} !== exp) begin
      fails++;
      $display("FAIL R%0d: irq_l_n,irq_r_n = %b expected %b", req, {irq_l_n, irq_r_n}, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input vec_t v);
    @(negedge clk); drive(v);
    @(negedge clk); check(int'(v.req), v.exp);
  endtask

  localparam vec_t IDLE = '{4'b0000, 10'h000, 4'b0000, 10'h000, 2'b11, 4'd0};

  initial begin
    #(200000 * 5.0);
    fails++; total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 2'b11);                       // R1 during reset
    rst_n = 1'b1;
    @(negedge clk); check(1, 2'b11);       // R1 after reset
    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R8: disable clears pending right flag
    @(negedge clk); drive(IDLE); en = 1'b0;
    @(negedge clk); check(8, 2'b11);
    // R8: right rings left while disabled -> dropped
    @(negedge clk); r_sel = 1; r_we = 1; r_addr = 10'h3FE;
    @(negedge clk); check(8, 2'b11);
    @(negedge clk); drive(IDLE); en = 1'b1;
    @(negedge clk); check(8, 2'b11);

    // R1: reset during operation with both flags pending
    @(negedge clk); l_sel = 1; l_we = 1; l_addr = 10'h3FF;
    r_sel = 1; r_we = 1; r_addr = 10'h3FE;
    @(negedge clk); check(2, 2'b00);
    drive(IDLE); rst_n = 1'b0;
    #1; check(1, 2'b11);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check(1, 2'b11);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule